// File: doc/BRIEF.md
# Element Batch Hazard Classifier

This block decides whether two vector elements fall into the same independent group, so that issue logic may skip dependency checks between them. A group is every element whose step number gives the same quotient when divided by a parallelism hint. The hint can be any value from 1 to 127, and it does not have to be a power of two. A hint of zero switches grouping off. The block runs two comparisons side by side: one for a pair of source steps and one for a pair of destination steps. The two results are fully independent of each other.

Callers pass the steps before remapping and before any predicate mask is applied. A memory-class input identifies operations that must never be batched. For those operations the block forces the hint to zero. The implementation may cap its group size with a parameter. When it does, each reported group is the intersection of the group under the requested hint and the group under the cap. Elements that the requested hint places in different groups are therefore never joined.

The block has a fixed two-cycle pipeline. It accepts one request on every clock and needs no handshake.

Top module: `batch_hazard_classifier`

## Requirements
- R1: A request with `in_valid` high in cycle n produces `out_valid` high after the second following rising clock edge and at no other time. A new request may be accepted on every cycle. While `out_valid` is low, `out_src_same`, `out_dst_same` and `out_hint_used` are all zero.
- R2: For a plain operation with a non-zero effective hint h that does not exceed the group cap, `out_src_same` is 1 exactly when floor(src_step_a/h) equals floor(src_step_b/h). This holds for any h, including values that are not powers of two.
- R3: `out_dst_same` is computed from the destination step pair by the same rule. It is independent of the source pair, so the two flags may differ in the same response.
- R4: A requested hint of 0 makes both flags 0 for every step pair.
- R5: `mem_kind` is encoded as 0 = plain, 1 = atomic, 2 = cache-inhibited, 3 = reservation/conditional. For any non-zero kind the hint is treated as 0: both flags read 0 and `out_hint_used` reads 0.
- R6: A hint larger than any step in use (for example 100 or 127) still groups by floor division with no clamping. With hint 100, steps 99 and 100 fall in different groups.
- R7: With parameter `GROUP_CAP` non-zero (default 24) and an effective hint greater than it, a flag is 1 only when both steps share a quotient under the hint and also under `GROUP_CAP`. Steps separated by the hint boundary are never reported as same.
- R8: For a plain operation with a non-zero hint, two identical steps are always reported as same.
- R9: While `rst` is high, and on the first cycles after it is released, all outputs are 0, even if requests are presented during reset.
- R10: `out_hint_used` returns the effective hint applied to the response: the requested `loop_hint` for plain operations and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request present this cycle |
| loop_hint | input | 7 | Horizontal-parallelism hint field taken from the loop state word |
| mem_kind | input | 2 | Operation class: 0 plain, 1 atomic, 2 cache-inhibited, 3 reservation/conditional |
| src_step_a | input | 7 | First source element step |
| src_step_b | input | 7 | Second source element step |
| dst_step_a | input | 7 | First destination element step |
| dst_step_b | input | 7 | Second destination element step |
| out_valid | output | 1 | Response present |
| out_src_same | output | 1 | Source steps share a group |
| out_dst_same | output | 1 | Destination steps share a group |
| out_hint_used | output | 7 | Effective hint applied to this response |

## Verification
Pairs that straddle a group edge, such as (h-1, h), are checked against pairs that lie inside one group and against identical steps. This separates a correct quotient compare from an off-by-one or truncated divider. Every hint from 0 to 127 is swept. The sweep includes odd and prime values, which expose any shortcut that assumes a power of two, and values above the cap, which expose a missing intersection with the cap grouping. Each memory class is applied to hints that would otherwise group. Source and destination pairs are chosen so that their flags disagree, which shows that the two paths are not cross-wired. Back-to-back requests with bubbles between them check the fixed latency and the zeroing of idle outputs.

// File: rtl/batch_cls_pkg.sv
package batch_cls_pkg;

    localparam int DEF_STEP_W = 7;
    localparam int DEF_HINT_W = 7;
    localparam int DEF_CAP    = 24;

    typedef enum logic [1:0] {
        MEM_PLAIN    = 2'd0,
        MEM_ATOMIC   = 2'd1,
        MEM_UNCACHED = 2'd2,
        MEM_RESERVE  = 2'd3
    } mem_kind_e;

    // Only plain operations may use the hint.
    function automatic logic hint_permitted(input mem_kind_e kind);
        return kind == MEM_PLAIN;
    endfunction

endpackage

// File: rtl/batch_floor_div.sv
module batch_floor_div #(
    parameter int W = 7
) (
    input  logic [W-1:0] num,
    input  logic [W-1:0] den,
    output logic [W-1:0] quo
);
    // Unrolled restoring division, one stage per quotient bit, MSB first.
    logic [W-1:0] rem_chain [0:W-1];

    assign rem_chain[0] = '0;

    for (genvar i = 0; i < W; i++) begin : g_stage
        localparam int BIT = W - 1 - i;
        logic [W:0] shifted;
        logic       fits;

        assign shifted  = {rem_chain[i], num[BIT]};
        assign fits     = shifted >= {1'b0, den};
        assign quo[BIT] = fits;

        if (i < W - 1) begin : g_next
            assign rem_chain[i+1] = fits ? W'(shifted - {1'b0, den}) : W'(shifted);
        end
    end
endmodule

// File: rtl/batch_pair_cmp.sv
module batch_pair_cmp #(
    parameter int W   = 7,
    parameter int CAP = 24
) (
    input  logic [W-1:0] step_a,
    input  logic [W-1:0] step_b,
    input  logic [W-1:0] hint,
    output logic         same
);
    localparam logic [W-1:0] CAP_V = W'(CAP);

    logic [W-1:0] q_a, q_b;
    logic         cap_agree;

    batch_floor_div #(.W(W)) u_div_a (.num(step_a), .den(hint), .quo(q_a));
    batch_floor_div #(.W(W)) u_div_b (.num(step_b), .den(hint), .quo(q_b));

    if (CAP != 0) begin : g_cap
        logic [W-1:0] c_a, c_b;
        batch_floor_div #(.W(W)) u_cdiv_a (.num(step_a), .den(CAP_V), .quo(c_a));
        batch_floor_div #(.W(W)) u_cdiv_b (.num(step_b), .den(CAP_V), .quo(c_b));
        // Group narrowed to the cap only when the hint exceeds it.
        assign cap_agree = (hint <= CAP_V) || (c_a == c_b);
    end else begin : g_nocap
        assign cap_agree = 1'b1;
    end

    assign same = (hint != '0) && (q_a == q_b) && cap_agree;
endmodule

// File: rtl/batch_hazard_classifier.sv
module batch_hazard_classifier
    import batch_cls_pkg::*;
#(
    parameter int STEP_W    = DEF_STEP_W,
    parameter int HINT_W    = DEF_HINT_W,
    parameter int GROUP_CAP = DEF_CAP
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [HINT_W-1:0] loop_hint,
    input  logic [1:0]        mem_kind,
    input  logic [STEP_W-1:0] src_step_a,
    input  logic [STEP_W-1:0] src_step_b,
    input  logic [STEP_W-1:0] dst_step_a,
    input  logic [STEP_W-1:0] dst_step_b,
    output logic              out_valid,
    output logic              out_src_same,
    output logic              out_dst_same,
    output logic [HINT_W-1:0] out_hint_used
);
    localparam int CW = (STEP_W > HINT_W) ? STEP_W : HINT_W;

    typedef struct packed {
        logic [STEP_W-1:0] a;
        logic [STEP_W-1:0] b;
    } step_pair_t;

    typedef struct packed {
        logic              valid;
        logic [HINT_W-1:0] hint;
        step_pair_t        src;
        step_pair_t        dst;
    } req_stage_t;

    typedef struct packed {
        logic              valid;
        logic              src_same;
        logic              dst_same;
        logic [HINT_W-1:0] hint;
    } rsp_stage_t;

    req_stage_t s1_q, s1_d;
    rsp_stage_t s2_q, s2_d;
    logic       src_same_c, dst_same_c;

    // Stage 1: choose effective hint and capture steps.
    always_comb begin
        s1_d.valid = in_valid;
        s1_d.hint  = hint_permitted(mem_kind_e'(mem_kind)) ? loop_hint : '0;
        s1_d.src   = '{a: src_step_a, b: src_step_b};
        s1_d.dst   = '{a: dst_step_a, b: dst_step_b};
        if (!in_valid) begin
            s1_d.hint = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
        end else begin
            s1_q <= s1_d;
        end
    end

    // Stage 2: quotient compares for both pairs.
    batch_pair_cmp #(.W(CW), .CAP(GROUP_CAP)) u_src_cmp (
        .step_a (CW'(s1_q.src.a)),
        .step_b (CW'(s1_q.src.b)),
        .hint   (CW'(s1_q.hint)),
        .same   (src_same_c)
    );

    batch_pair_cmp #(.W(CW), .CAP(GROUP_CAP)) u_dst_cmp (
        .step_a (CW'(s1_q.dst.a)),
        .step_b (CW'(s1_q.dst.b)),
        .hint   (CW'(s1_q.hint)),
        .same   (dst_same_c)
    );

    always_comb begin
        s2_d.valid    = s1_q.valid;
        s2_d.src_same = s1_q.valid && src_same_c;
        s2_d.dst_same = s1_q.valid && dst_same_c;
        s2_d.hint     = s1_q.valid ? s1_q.hint : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s2_q <= '0;
        end else begin
            s2_q <= s2_d;
        end
    end

    assign out_valid     = s2_q.valid;
    assign out_src_same  = s2_q.src_same;
    assign out_dst_same  = s2_q.dst_same;
    assign out_hint_used = s2_q.hint;
endmodule

// File: rtl/batch_hazard_classifier_chk.sv
module batch_hazard_classifier_chk #(
    parameter int STEP_W = 7,
    parameter int HINT_W = 7
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic [HINT_W-1:0] loop_hint,
    input logic [1:0]        mem_kind,
    input logic [STEP_W-1:0] src_step_a,
    input logic [STEP_W-1:0] src_step_b,
    input logic              out_valid,
    input logic              out_src_same,
    input logic              out_dst_same,
    input logic [HINT_W-1:0] out_hint_used
);
    p_latency_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);

    p_no_spurious_r1: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (!out_src_same && !out_dst_same && out_hint_used == '0));

    p_zero_hint_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && loop_hint == '0) |=> ##1 (!out_src_same && !out_dst_same));

    p_mem_forced_r5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mem_kind != 2'd0) |=> ##1
            (out_hint_used == '0 && !out_src_same && !out_dst_same));

    p_identical_r8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mem_kind == 2'd0 && loop_hint != '0 && src_step_a == src_step_b)
            |=> ##1 out_src_same);

    p_hint_report_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mem_kind == 2'd0) |=> ##1 (out_hint_used == $past(loop_hint, 2)));
endmodule

bind batch_hazard_classifier batch_hazard_classifier_chk #(
    .STEP_W (STEP_W),
    .HINT_W (HINT_W)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .in_valid      (in_valid),
    .loop_hint     (loop_hint),
    .mem_kind      (mem_kind),
    .src_step_a    (src_step_a),
    .src_step_b    (src_step_b),
    .out_valid     (out_valid),
    .out_src_same  (out_src_same),
    .out_dst_same  (out_dst_same),
    .out_hint_used (out_hint_used)
);

// File: tb/test_batch_hazard_classifier.sv
module test_batch_hazard_classifier;
    // Time unit taken as 1 ns: 20-unit period gives a 50 MHz clock.
    localparam int HALF = 10;
    localparam int CAP  = 24;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [6:0] loop_hint = '0;
    logic [1:0] mem_kind = '0;
    logic [6:0] src_step_a = '0, src_step_b = '0, dst_step_a = '0, dst_step_b = '0;
    logic       out_valid, out_src_same, out_dst_same;
    logic [6:0] out_hint_used;

    int  total = 0;
    int  bad = 0;
    bit  done = 0;
    int  seed = 12345;

    typedef struct {
        bit       v;
        bit       s;
        bit       d;
        bit [6:0] h;
        string    tag;
    } exp_t;

    exp_t pipe_q[$];

    always #HALF clk = ~clk;

    batch_hazard_classifier i_batch_hazard_classifier (
        .clk (clk), .rst (rst), .in_valid (in_valid), .loop_hint (loop_hint),
        .mem_kind (mem_kind), .src_step_a (src_step_a), .src_step_b (src_step_b),
        .dst_step_a (dst_step_a), .dst_step_b (dst_step_b), .out_valid (out_valid),
        .out_src_same (out_src_same), .out_dst_same (out_dst_same),
        .out_hint_used (out_hint_used)
    );

    function automatic bit ref_same(input int a, input int b, input int h);
        bit r;
        if (h == 0) return 0;
        r = (a / h) == (b / h);
        if (CAP != 0 && h > CAP) r = r && ((a / CAP) == (b / CAP));
        return r;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic cycle(input bit v, input int h, input int k,
                         input int sa, input int sb, input int da, input int db,
                         input string tag);
        exp_t e;
        int   heff;
        @(negedge clk);
        if (pipe_q.size() == 2) begin
            e = pipe_q.pop_front();
            check(e.tag, "out_valid", out_valid, e.v);
            check(e.tag, "out_src_same", out_src_same, e.s);
            check(e.tag, "out_dst_same", out_dst_same, e.d);
            check(e.tag, "out_hint_used", out_hint_used, e.h);
        end
        in_valid   = v;
        loop_hint  = 7'(h);
        mem_kind   = 2'(k);
        src_step_a = 7'(sa);
        src_step_b = 7'(sb);
        dst_step_a = 7'(da);
        dst_step_b = 7'(db);
        heff  = (v && k == 0) ? h : 0;
        e.v   = v;
        e.s   = v && ref_same(sa, sb, heff);
        e.d   = v && ref_same(da, db, heff);
        e.h   = v ? 7'(heff) : 7'd0;
        e.tag = tag;
        pipe_q.push_back(e);
    endtask

    function automatic int rnd7();
        seed = seed * 1103515245 + 12345;
        return (seed >>> 16) & 127;
    endfunction

    initial begin
        // R9: requests during reset must not appear at outputs
        repeat (2) @(negedge clk);
        in_valid = 1'b1; loop_hint = 7'd5; src_step_a = 7'd1; src_step_b = 7'd2;
        repeat (3) @(negedge clk);
        check("R9", "out_valid", out_valid, 0);
        check("R9", "out_src_same", out_src_same, 0);
        check("R9", "out_hint_used", out_hint_used, 0);
        in_valid = 1'b0;
        rst = 1'b0;
        @(negedge clk);
        check("R9", "out_valid", out_valid, 0);

        // R2: non-power-of-two hints, boundary and inside pairs
        cycle(1, 3, 0, 2, 3, 3, 5, "R2");
        cycle(1, 5, 0, 4, 5, 5, 9, "R2");
        cycle(1, 7, 0, 13, 14, 7, 13, "R2");
        cycle(1, 1, 0, 6, 7, 6, 6, "R2");
        // R3: source and destination disagree
        cycle(1, 6, 0, 0, 5, 5, 6, "R3");
        cycle(1, 6, 0, 11, 12, 12, 17, "R3");
        // R4: hint zero
        cycle(1, 0, 0, 4, 4, 9, 9, "R4");
        // R5: forbidden memory classes
        cycle(1, 10, 1, 2, 3, 4, 5, "R5");
        cycle(1, 10, 2, 2, 3, 4, 5, "R5");
        cycle(1, 10, 3, 7, 7, 4, 5, "R5");
        // R6: hint beyond vector range
        cycle(1, 100, 0, 99, 100, 0, 23, "R6");
        cycle(1, 127, 0, 0, 126, 126, 127, "R6");
        // R7: hint above cap split by cap, and by hint
        cycle(1, 40, 0, 10, 30, 30, 40, "R7");
        cycle(1, 40, 0, 24, 39, 0, 23, "R7");
        cycle(1, 24, 0, 0, 23, 23, 24, "R7");
        // R8: identical steps
        cycle(1, 9, 0, 77, 77, 126, 126, "R8");
        // R1: bubble and back-to-back
        cycle(0, 9, 0, 1, 1, 1, 1, "R1");
        cycle(1, 9, 0, 1, 2, 8, 9, "R1");
        cycle(0, 0, 0, 0, 0, 0, 0, "R1");

        // Sweep of every hint value
        for (int h = 0; h < 128; h++) begin
            int k;
            int r;
            k = (h % 7 == 3) ? (h % 4) : 0;
            if (h > 0) cycle(1, h, k, h - 1, h, h, h + 1 > 127 ? 127 : h + 1, "R2");
            r = rnd7();
            cycle(1, h, k, r, r, rnd7(), rnd7(), "R8");
            cycle(1, h, k, rnd7(), rnd7(), rnd7(), rnd7(), h > CAP ? "R7" : "R3");
            cycle(1, h, (h % 4), rnd7(), rnd7(), rnd7(), rnd7(), "R5");
            cycle(1, h, 0, rnd7(), rnd7(), 0, h > 63 ? 63 : h, "R10");
            if (h % 5 == 0) cycle(0, h, 0, 0, 0, 0, 0, "R1");
        end

        repeat (3) cycle(0, 0, 0, 0, 0, 0, 0, "R1");
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(2 * HALF * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule